// File: doc/BRIEF.md
# Compare-Based Six-Output PWM Generator with ADC Trigger

A single timebase counter drives three compare channels. Each channel drives a pair of PWM outputs, so the block has six outputs. The counter runs either as a sawtooth (up counting, which gives asymmetric edges) or as a triangle (up-down counting, which gives centre-aligned edges). A power-of-two prescaler sets how fast the counter advances. A period value sets the top of the count, and one compare value per channel sets the duty. Period and compare values are shadowed: they take effect only while the counter sits at zero.

A 12-bit action field gives every output its own 2-bit code. The code holds the output at a fixed level, or passes the channel's raw compare signal either true or inverted. A start-of-conversion pulse for an external converter can be tied to counter underflow, period match or channel-0 compare match, or it can be switched off.

The counting direction is held in a two-state machine. COUNT_UP has three transitions. It stays in COUNT_UP while incrementing, or on wrap in up mode. It goes UP_TO_DOWN on reaching the period in up-down mode when the next value is non-zero. It stays in COUNT_UP when the period is 0 or 1. COUNT_DOWN has two transitions. It goes DOWN_TO_UP when the count would reach zero. It goes MODE_EXIT when up-down mode is deselected; this returns to COUNT_UP and applies the sawtooth rule. The state changes only on a prescaled tick.

Top module: `cmp_pwm_timer`

## Requirements
- R1: The counter changes only on a prescaled tick. With divider select N, a tick occurs once every 2^N clocks, and the first tick comes on the 2^N-th clock edge after reset is released.
- R2: With `updown_mode`=0 the counter steps 0,1,…,P and then returns to 0, where P is the period in effect.
- R3: With `updown_mode`=1 the counter steps 0,1,…,P,P-1,…,1,0 and repeats, giving a cycle of 2P ticks. With P=0 it stays at 0.
- R4: The raw signal of channel k is 1 while the counter is below that channel's compare value in effect. Channel k feeds outputs 2k and 2k+1.
- R5: Output j is controlled by bits [2j+1:2j] of `action_word`. Code 00 gives a constant 0, 01 gives the inverted raw signal, 10 gives the raw signal, and 11 gives a constant 1. For example, 0xC96 sets the outputs, from 0 to 5, to true, inverted, inverted, true, constant 0 and constant 1.
- R6: The period value in effect is `period_in` while the counter is 0. At other times it is the value that was captured during the last clock with the counter at 0.
- R7: Each compare value in effect follows the same shadow rule as R6, using that channel's slice of `compare_in`. Channel k uses bits [CNT_W*k+CNT_W-1 : CNT_W*k].
- R8: `soc_sel` selects the trigger: 01 is underflow (the new count is 0), 10 is period match (the new count equals the period), and 11 is compare match (the new count equals the channel-0 compare value). `soc_pulse` is high for exactly the clock in which the counter shows the value reached by that tick.
- R9: With `soc_sel`=00, `soc_pulse` stays 0.
- R10: While reset is held, the counter reads 0, `soc_pulse` is 0, and the outputs follow R4/R5 using the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| updown_mode | input | 1 | 0 sawtooth, 1 triangle counting |
| clk_div_sel | input | PRE_W | Prescaler exponent N (divide by 2^N) |
| period_in | input | CNT_W | Period value, shadowed |
| compare_in | input | NUM_CH*CNT_W | Compare values, channel k in slice k, shadowed |
| action_word | input | 4*NUM_CH | 2-bit action code per output |
| soc_sel | input | 2 | Start-of-conversion trigger select |
| pwm_out | output | 2*NUM_CH | PWM outputs |
| soc_pulse | output | 1 | One-clock start-of-conversion pulse |
| counter_value | output | CNT_W | Present timebase count |

## Verification
The bench builds the block with CNT_W=8 and PRE_W=2, so divide ratios 1 to 8 are reachable. It keeps three channels. It sweeps both counting modes, three divider settings, periods 0, 1 and 5, compare values at 0, mid-range, equal to the period and above the period, all four trigger selects, and several action words. Every cycle is compared with closed-form expected values for the count, all six outputs and the trigger. Small periods make the degenerate cases reachable: a counter stuck at zero, and a one-step triangle. A separate sequence changes the period and a compare value mid-cycle, to show that both take effect only at the next zero.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic {
        COUNT_UP   = 1'b0,
        COUNT_DOWN = 1'b1
    } dir_state_t;

    typedef enum logic [1:0] {
        SOC_OFF   = 2'b00,
        SOC_ZERO  = 2'b01,
        SOC_TOP   = 2'b10,
        SOC_MATCH = 2'b11
    } soc_src_t;

    localparam logic [1:0] CODE_LOW  = 2'b00;
    localparam logic [1:0] CODE_INV  = 2'b01;
    localparam logic [1:0] CODE_TRUE = 2'b10;
    localparam logic [1:0] CODE_HIGH = 2'b11;
endpackage

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] div_sel,
    output logic             tick
);
    localparam int DIV_W = (1 << PRE_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_mask;

    always_comb begin
        div_mask = DIV_W'((32'd1 << div_sel) - 32'd1);
        tick     = (div_cnt >= div_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_cnt <= '0;
        else if (tick)   div_cnt <= '0;
        else             div_cnt <= div_cnt + {{(DIV_W-1){1'b0}}, 1'b1};
    end

    // R1: with divide-by-one selected every clock is a tick
    assert_div1_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == '0) |-> tick)
        else $error("prescaler idle with divide-by-one");
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             updown,
    input  logic [CNT_W-1:0] period_in,
    input  logic             cmp_hit_nx,
    input  logic [1:0]       soc_sel,
    output logic [CNT_W-1:0] cnt_nx,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cnt_zero,
    output logic             soc_q
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    dir_state_t       st_q, st_nx;
    logic [CNT_W-1:0] per_act, per_eff;
    logic             soc_nx;

    always_comb begin
        cnt_zero = (cnt_q == '0);
        per_eff  = cnt_zero ? period_in : per_act;
    end

    // next state and next count
    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        if (tick) begin
            unique case (st_q)
                COUNT_UP: begin
                    if (!updown) begin
                        cnt_nx = (cnt_q >= per_eff) ? '0 : cnt_q + ONE;
                    end else if (cnt_q < per_eff) begin
                        cnt_nx = cnt_q + ONE;
                    end else if (cnt_q > ONE) begin
                        cnt_nx = cnt_q - ONE;
                        st_nx  = COUNT_DOWN;
                    end else begin
                        cnt_nx = '0;
                    end
                end
                COUNT_DOWN: begin
                    if (!updown) begin
                        st_nx  = COUNT_UP;
                        cnt_nx = (cnt_q >= per_eff) ? '0 : cnt_q + ONE;
                    end else if (cnt_q > ONE) begin
                        cnt_nx = cnt_q - ONE;
                    end else begin
                        cnt_nx = '0;
                        st_nx  = COUNT_UP;
                    end
                end
            endcase
        end
    end

    always_comb begin
        soc_nx = 1'b0;
        if (tick) begin
            unique case (soc_src_t'(soc_sel))
                SOC_OFF:   soc_nx = 1'b0;
                SOC_ZERO:  soc_nx = (cnt_nx == '0);
                SOC_TOP:   soc_nx = (cnt_nx == per_eff);
                SOC_MATCH: soc_nx = cmp_hit_nx;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= COUNT_UP;
        else        st_q <= st_nx;
    end

    // registered outputs and shadow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            per_act <= '0;
            soc_q   <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            soc_q <= soc_nx;
            if (cnt_zero) per_act <= period_in;
        end
    end

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q))
        else $error("counter moved without tick");

    assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_eff)
        else $error("counter above period");

    assert_down_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == COUNT_DOWN && tick && updown) |=> (cnt_q < $past(cnt_q)))
        else $error("down state did not decrement");

    assert_period_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_zero |=> $stable(per_act))
        else $error("period shadow changed away from zero");

    assert_soc_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (soc_sel == SOC_OFF) |=> !soc_q)
        else $error("trigger pulsed while disabled");
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
    import cpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter bit IS_REF = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_nx,
    input  logic             cnt_zero,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic [1:0]       code_a,
    input  logic [1:0]       code_b,
    output logic             hit_nx,
    output logic [1:0]       pwm_pair
);
    logic [CNT_W-1:0] cmp_act, cmp_eff;
    logic             raw;

    function automatic logic drive(input logic [1:0] code, input logic r);
        unique case (code)
            CODE_LOW:  drive = 1'b0;
            CODE_INV:  drive = ~r;
            CODE_TRUE: drive = r;
            CODE_HIGH: drive = 1'b1;
        endcase
    endfunction

    always_comb begin
        cmp_eff     = cnt_zero ? cmp_in : cmp_act;
        raw         = (cnt_q < cmp_eff);
        hit_nx      = IS_REF && (cnt_nx == cmp_eff);
        pwm_pair[0] = drive(code_a, raw);
        pwm_pair[1] = drive(code_b, raw);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cmp_act <= '0;
        else if (cnt_zero) cmp_act <= cmp_in;
    end

    assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_zero |=> $stable(cmp_act))
        else $error("compare shadow changed away from zero");

    assert_pair_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_a == code_b) |-> (pwm_pair[0] == pwm_pair[1]))
        else $error("pair outputs disagree with equal codes");
endmodule

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer #(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 3,
    parameter int NUM_CH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    updown_mode,
    input  logic [PRE_W-1:0]        clk_div_sel,
    input  logic [CNT_W-1:0]        period_in,
    input  logic [NUM_CH*CNT_W-1:0] compare_in,
    input  logic [4*NUM_CH-1:0]     action_word,
    input  logic [1:0]              soc_sel,
    output logic [2*NUM_CH-1:0]     pwm_out,
    output logic                    soc_pulse,
    output logic [CNT_W-1:0]        counter_value
);
    logic             tick;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             cnt_zero;
    logic [NUM_CH-1:0] hit_vec;
    logic             cmp_hit_nx;

    assign cmp_hit_nx    = |hit_vec;
    assign counter_value = cnt_q;

    cpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (clk_div_sel),
        .tick    (tick)
    );

    cpwm_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .updown     (updown_mode),
        .period_in  (period_in),
        .cmp_hit_nx (cmp_hit_nx),
        .soc_sel    (soc_sel),
        .cnt_nx     (cnt_nx),
        .cnt_q      (cnt_q),
        .cnt_zero   (cnt_zero),
        .soc_q      (soc_pulse)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [1:0] pair;
        cpwm_channel #(.CNT_W(CNT_W), .IS_REF(g == 0)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_q    (cnt_q),
            .cnt_nx   (cnt_nx),
            .cnt_zero (cnt_zero),
            .cmp_in   (compare_in[g*CNT_W +: CNT_W]),
            .code_a   (action_word[4*g +: 2]),
            .code_b   (action_word[4*g+2 +: 2]),
            .hit_nx   (hit_vec[g]),
            .pwm_pair (pair)
        );
        assign pwm_out[2*g +: 2] = pair;
    end
endmodule

// File: tb/tb_cmp_pwm_timer.sv
module tb_cmp_pwm_timer;
    localparam int CW = 8;
    localparam int PW = 2;
    localparam int NC = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            updown_mode = 1'b0;
    logic [PW-1:0]   clk_div_sel = '0;
    logic [CW-1:0]   period_in = '0;
    logic [NC*CW-1:0] compare_in = '0;
    logic [4*NC-1:0] action_word = '0;
    logic [1:0]      soc_sel = 2'b00;
    logic [2*NC-1:0] pwm_out;
    logic            soc_pulse;
    logic [CW-1:0]   counter_value;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cmp_pwm_timer #(.CNT_W(CW), .PRE_W(PW), .NUM_CH(NC)) dut (
        .clk(clk), .rst_n(rst_n), .updown_mode(updown_mode),
        .clk_div_sel(clk_div_sel), .period_in(period_in),
        .compare_in(compare_in), .action_word(action_word),
        .soc_sel(soc_sel), .pwm_out(pwm_out), .soc_pulse(soc_pulse),
        .counter_value(counter_value)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_cnt(int t, int per, bit ud);
        int p;
        if (per == 0) return 0;
        if (!ud) return t % (per + 1);
        p = t % (2 * per);
        return (p <= per) ? p : 2 * per - p;
    endfunction

    // R4/R5: raw = count < compare, code per output slot
    function automatic logic [5:0] exp_pwm(int e, int c0, int c1, int c2, logic [11:0] aw);
        logic [5:0] r;
        for (int j = 0; j < 6; j++) begin
            int cv;
            bit raw;
            logic [1:0] code;
            cv   = (j < 2) ? c0 : ((j < 4) ? c1 : c2);
            raw  = (e < cv);
            code = aw[2*j +: 2];
            case (code)
                2'b00: r[j] = 1'b0;
                2'b01: r[j] = ~raw;
                2'b10: r[j] = raw;
                default: r[j] = 1'b1;
            endcase
        end
        return r;
    endfunction

    function automatic logic [11:0] pick_aw(int i);
        case (i % 4)
            0: return 12'hC96;
            1: return 12'h369;
            2: return 12'hE4B;
            default: return 12'h1B2;
        endcase
    endfunction

    task automatic run_cfg(bit ud, int n, int per, int c0, int sel, logic [11:0] aw);
        int c1, c2, cycles;
        c1 = per;
        c2 = (per + 1 > c0) ? per + 1 - c0 : 0;
        @(negedge clk);
        rst_n       = 1'b0;
        updown_mode = ud;
        clk_div_sel = PW'(n);
        period_in   = CW'(per);
        compare_in  = {CW'(c2), CW'(c1), CW'(c0)};
        action_word = aw;
        soc_sel     = 2'(sel);
        @(negedge clk);
        // R10: reset state
        chk(counter_value == 0, "R10 count in reset", counter_value, 0);
        chk(soc_pulse == 1'b0, "R10 trigger in reset", soc_pulse, 0);
        chk(pwm_out == exp_pwm(0, c0, c1, c2, aw), "R10 outputs in reset",
            pwm_out, exp_pwm(0, c0, c1, c2, aw));
        rst_n = 1'b1;
        cycles = (4 * per + 3) << n;
        for (int k = 0; k < cycles; k++) begin
            int t, e;
            bit tk, se;
            @(negedge clk);
            t  = (k + 1) >> n;
            tk = ((k + 1) % (1 << n)) == 0;
            e  = exp_cnt(t, per, ud);
            chk(counter_value == CW'(e), (n > 0) ? "R1 prescaled count" : (ud ? "R3 triangle count" : "R2 sawtooth count"),
                counter_value, e);
            chk(pwm_out == exp_pwm(e, c0, c1, c2, aw), "R4 R5 outputs",
                pwm_out, exp_pwm(e, c0, c1, c2, aw));
            case (sel)
                1: se = tk && (e == 0);
                2: se = tk && (e == per);
                3: se = tk && (e == c0);
                default: se = 1'b0;
            endcase
            chk(soc_pulse == se, (sel == 0) ? "R9 trigger off" : "R8 trigger",
                soc_pulse, se);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int idx;
        idx = 0;
        // sweep: R1 R2 R3 R4 R5 R8 R9 R10
        for (int ud = 0; ud < 2; ud++)
            for (int n = 0; n < 3; n++)
                for (int pi = 0; pi < 3; pi++)
                    for (int ci = 0; ci < 3; ci++)
                        for (int sel = 0; sel < 4; sel++) begin
                            int per, c0;
                            per = (pi == 0) ? 0 : ((pi == 1) ? 1 : 5);
                            c0  = (ci == 0) ? 0 : ((ci == 1) ? per / 2 + 1 : per + 1);
                            run_cfg(ud[0], n, per, c0, sel, pick_aw(idx));
                            idx++;
                        end

        // R6 R7: shadow loading, sawtooth, period 9, channel-0 compare 3
        @(negedge clk);
        rst_n       = 1'b0;
        updown_mode = 1'b0;
        clk_div_sel = '0;
        period_in   = 8'd9;
        compare_in  = {8'd10, 8'd9, 8'd3};
        action_word = 12'hC96;
        soc_sel     = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) @(negedge clk);
        chk(counter_value == 8'd5, "R6 pre-change count", counter_value, 5);
        period_in  = 8'd3;
        compare_in = {8'd10, 8'd9, 8'd7};
        for (int i = 1; i <= 12; i++) begin
            int ce;
            bit re;
            @(negedge clk);
            ce = (i <= 4) ? 5 + i : (i - 5) % 4;
            re = (i >= 5);
            chk(counter_value == CW'(ce), "R6 period shadow", counter_value, ce);
            chk(pwm_out[0] == re, "R7 compare shadow", pwm_out[0], re);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule